// File: doc/BRIEF.md
# Variable-Block Carry-Select Adder

A purely combinational 16-bit binary adder with a carry input, a 16-bit sum and a carry output. The operand bits are cut into five slices. From least to most significant the slices are 1, 2, 3, 4 and 6 bits wide.

The lowest slice is a plain ripple adder fed by the real carry input. Each higher slice precomputes two ripple results in parallel. One result assumes an incoming carry of 0 and the other assumes 1. A 2-to-1 multiplexer then picks one of the two, steered by the carry that the slice below actually produced.

The selected carries form a chain of multiplexers across the slices. The slices widen toward the top so that each slice's two ripple results are ready by the time its select carry arrives.

The block is meant for a datapath stage that needs a sum faster than a full ripple chain gives, without the wiring of a lookahead tree.

Top module: `csel_adder`

## Requirements
- R1: For every pair of operands and either carry input, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a 17-bit unsigned sum.
- R2: Slice boundaries sit after bits 0, 2, 5 and 9. A carry generated in the top bit of any slice reaches the first bit of the next slice, e.g. 16'h0007 + 16'h0001 gives 16'h0008.
- R3: cin_i enters bit 0 directly. Toggling cin_i with zero operands toggles sum_o[0] and nothing else.
- R4: cout_o is the selected carry of the top slice. All-ones plus one, whether the one comes from b_i or from cin_i, gives sum_o = 0 and cout_o = 1.
- R5: When no bit position has both operand bits set and cin_i is 0, sum_o equals a_i | b_i and cout_o is 0.
- R6: A run of ones ending at any bit position k, plus one, carries through every slice boundary below k+1: (2^(k+1)-1) + 1 yields 2^(k+1) modulo 2^16, with cout_o = 1 only for k = 15.
- R7: The outputs hold no state. The same inputs give the same outputs whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The bench builds the adder with its default slice widths of 1, 2, 3, 4 and 6 bits. These defaults give a 16-bit operand and four slice boundaries.

At that width a walk of a ones-run across all sixteen positions touches every boundary and the final carry-out. All-ones operands are cheap to drive directly.

Random operand pairs are each applied with both carry inputs. This exercises both precomputed halves of every upper slice against an arithmetic reference model.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned MAX_BLK = 8;
  localparam int unsigned VEC_W   = MAX_BLK * 8;

  // width of slice i, packed 8 bits per slice, slice 0 in the low byte
  function automatic int unsigned blk_w(input logic [VEC_W-1:0] w_vec, input int unsigned i);
    return int'(w_vec[i*8 +: 8]);
  endfunction

  // lowest bit index of slice i
  function automatic int unsigned blk_off(input logic [VEC_W-1:0] w_vec, input int unsigned i);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < i; j++) acc += int'(w_vec[j*8 +: 8]);
    return acc;
  endfunction
endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0]   c;
  logic [W-1:0] g, p;

  assign c[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i]   = a_i[i] & b_i[i];
    assign p[i]   = a_i[i] ^ b_i[i];
    assign s_o[i] = p[i] ^ c[i];
    assign c[i+1] = g[i] | (p[i] & c[i]);
  end

  assign co_o = c[W];
endmodule

// File: rtl/csel_block.sv
module csel_block #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  csel_rca #(.W(W)) u_rca0 (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (1'b0),
    .s_o  (s0),
    .co_o (c0)
  );

  csel_rca #(.W(W)) u_rca1 (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (1'b1),
    .s_o  (s1),
    .co_o (c1)
  );

  assign sum_o  = sel_i ? s1 : s0;
  assign cout_o = sel_i ? c1 : c0;
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int unsigned NUM_BLK = 5,
  parameter logic [NUM_BLK*8-1:0] BLK_W = 40'h06_04_03_02_01,
  localparam int unsigned WIDTH =
    csel_pkg::blk_off(csel_pkg::VEC_W'(BLK_W), NUM_BLK)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam logic [csel_pkg::VEC_W-1:0] WV = csel_pkg::VEC_W'(BLK_W);

  // selected carry into each slice; c[NUM_BLK] leaves the top slice
  logic [NUM_BLK:0] c;
  assign c[0] = cin_i;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    localparam int unsigned W   = csel_pkg::blk_w(WV, k);
    localparam int unsigned OFF = csel_pkg::blk_off(WV, k);

    if (k == 0) begin : g_base
      // lowest slice sees the true carry, no duplicate needed
      csel_rca #(.W(W)) u_rca (
        .a_i  (a_i[OFF +: W]),
        .b_i  (b_i[OFF +: W]),
        .ci_i (c[k]),
        .s_o  (sum_o[OFF +: W]),
        .co_o (c[k+1])
      );
    end else begin : g_sel
      csel_block #(.W(W)) u_blk (
        .a_i    (a_i[OFF +: W]),
        .b_i    (b_i[OFF +: W]),
        .sel_i  (c[k]),
        .sum_o  (sum_o[OFF +: W]),
        .cout_o (c[k+1])
      );
    end
  end

  assign cout_o = c[NUM_BLK];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    a_r1_sum_matches: assert ({cout_o, sum_o} == ref_sum)
      else $error("R1 sum mismatch");
    a_r3_bit0_parity: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("R3 bit0 mismatch");
    if (a_i == ~b_i && cin_i) begin
      a_r4_all_ones_wrap: assert (cout_o && sum_o == '0)
        else $error("R4 wrap mismatch");
    end
    if ((a_i & b_i) == '0 && !cin_i) begin
      a_r5_no_carry_or: assert (!cout_o && sum_o == (a_i | b_i))
        else $error("R5 carry-free mismatch");
    end
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/csel_adder_tb_top.sv
module csel_adder_tb_top;
  localparam int unsigned W = 16;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
  } vec_t;

  localparam int unsigned NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    '{16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
    '{16'h0001, 16'h0000, 1'b1, 16'h0002, 1'b0},
    '{16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
    '{16'h0001, 16'h0001, 1'b0, 16'h0002, 1'b0},
    '{16'h0007, 16'h0001, 1'b0, 16'h0008, 1'b0},
    '{16'h003F, 16'h0001, 1'b0, 16'h0040, 1'b0},
    '{16'h03FF, 16'h0001, 1'b0, 16'h0400, 1'b0},
    '{16'hFC00, 16'h0400, 1'b0, 16'h0000, 1'b1},
    '{16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
    '{16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
    '{16'h8000, 16'h8000, 1'b1, 16'h0001, 1'b1},
    '{16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    '{16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0}
  };

  logic         clk;
  logic         rst_ni;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_run;
  int           n_fail;
  bit           done;

  csel_adder dut_i (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
    @(negedge clk);
    a   = ta;
    b   = tb;
    cin = tc;
    #5;
  endtask

  task automatic check(input string req, input logic [W-1:0] es, input logic ec);
    n_run++;
    if (sum !== es || cout !== ec) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b: got sum=%h cout=%b exp sum=%h cout=%b",
               req, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [W:0] ref17;
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    a      = '0;
    b      = '0;
    cin    = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // state after reset with idle inputs
    apply('0, '0, 1'b0);
    check("R1 reset", '0, 1'b0);

    // vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].ci);
      check($sformatf("R1 vec%0d", i), VECS[i].s, VECS[i].co);
    end

    // R3: cin toggles only bit 0
    apply('0, '0, 1'b1);
    check("R3 cin high", 16'h0001, 1'b0);
    apply('0, '0, 1'b0);
    check("R3 cin low", 16'h0000, 1'b0);

    // R4: all-ones plus one from either source
    apply(16'hFFFF, 16'h0001, 1'b0);
    check("R4 b plus one", '0, 1'b1);
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R4 cin plus one", '0, 1'b1);

    // R5: disjoint operands
    apply(16'hA5A0, 16'h5A0F, 1'b0);
    check("R5 disjoint", 16'hFFAF, 1'b0);

    // R6: ones-run walk across every slice boundary
    for (int k = 0; k < W; k++) begin
      logic [W:0] run;
      run = (17'd1 << (k + 1)) - 17'd1;
      apply(run[W-1:0], 16'h0001, 1'b0);
      ref17 = run + 17'd1;
      check($sformatf("R6 k=%0d", k), ref17[W-1:0], ref17[W]);
    end

    // R1: random operands with both carry inputs
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      for (int c = 0; c < 2; c++) begin
        apply(ra, rb, c[0]);
        ref17 = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, c[0]};
        check("R1 random", ref17[W-1:0], ref17[W]);
      end
    end

    // R7: earlier vector repeated after unrelated traffic
    apply(16'h1234, 16'h4321, 1'b0);
    check("R7 repeat", 16'h5555, 1'b0);
    apply(16'hFFFF, 16'h0001, 1'b0);
    check("R7 repeat wrap", 16'h0000, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule